// File: doc/BRIEF.md
# Dual-Use Pin Control Register Bank

This block owns one package pin that can serve two purposes. In function mode the pin drives out a clock that is generated elsewhere. In general-purpose mode the pin is either an input that software samples, or an output that software drives. Software works the block through a small synchronous register port that is 32 bits wide. There is a mode-select register, a direction register, a read-only input register, a data-out register, and two alias words. Writing a 1 to an alias forces data-out high or low, so software never has to read, modify and write the data-out register.

The selected mode is held in a three-state machine with the states PM_FUNC, PM_GIO_IN and PM_GIO_OUT. Reset enters PM_FUNC. The machine moves as follows:
- Writing 0 to mode-select leaves PM_FUNC. It goes to PM_GIO_OUT if the direction bit is 1 and to PM_GIO_IN if it is 0.
- Writing 1 to mode-select returns to PM_FUNC from either GIO state.
- Writing the direction register while in a GIO state moves between PM_GIO_IN and PM_GIO_OUT.
- Writing the direction register while in PM_FUNC only stores the bit.

Top module: `pinctl_bank`

## Requirements
- R1: After reset the state is PM_FUNC, the direction and data-out bits are 0, bus_rdata is 0, pin_oe is 1 and pin_out follows func_clk.
- R2: Writing a word with bit 0 set to offset 0x10 sets data-out to 1. In PM_GIO_OUT, pin_out is 1 from the first cycle after the write edge.
- R3: Writing a word with bit 0 set to offset 0x14 clears data-out to 0. In PM_GIO_OUT, pin_out is 0 from the first cycle after the write edge.
- R4: Writing a word with bit 0 clear to offset 0x10 or 0x14 leaves data-out and pin_out unchanged.
- R5: Reading offset 0x10 or 0x14 returns data-out in bit 0 while the state is PM_GIO_OUT, and returns an all-zero word in any other state.
- R6: Bits 31:1 of every register read as 0, and the upper bits of written data have no effect.
- R7: Mode-select is bit 0 at offset 0x00 and direction is bit 0 at offset 0x04. Both read back as written. The pin outputs per state are:
  - PM_FUNC: pin_oe=1 and pin_out=func_clk.
  - PM_GIO_OUT: pin_oe=1 and pin_out=data-out.
  - PM_GIO_IN: pin_oe=0 and pin_out=0.
- R8: Offset 0x08 bit 0 reads pin_in through a two-flop synchronizer. A change of pin_in is visible to a read issued on the third clock edge after the change. Writes to 0x08 are ignored.
- R9: Offset 0x0C bit 0 is the data-out bit. It can be read and written, and it reads back in every state.
- R10: bus_rdata is registered. It loads the addressed word on an edge where bus_rd is 1 and holds its value otherwise. Unmapped offsets read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | AW (8) | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DW (32) | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DW (32) | Registered read data |
| func_clk | input | 1 | Clock driven out in function mode |
| pin_in | input | 1 | Pad input value, asynchronous |
| pin_out | output | 1 | Value driven toward the pad |
| pin_oe | output | 1 | Output enable toward the pad |

## Verification
A wrong mode state appears on pin_oe or on the source of pin_out in the first cycle after the write that caused it, before any read. A corrupted data-out bit is visible on pin_out in the same cycle whenever the state is PM_GIO_OUT. In the other states it shows up only through a read of 0x0C, one edge after the read strobe. A mis-gated alias read shows up as a nonzero alias word in PM_FUNC or PM_GIO_IN. A wrong synchronizer depth shifts the 0x08 readback by one or more cycles against a stepped pin_in.

// File: rtl/pinctl_pkg.sv
package pinctl_pkg;

    typedef enum logic [1:0] {
        PM_FUNC    = 2'd0,
        PM_GIO_IN  = 2'd1,
        PM_GIO_OUT = 2'd2
    } pin_mode_e;

    localparam int unsigned OFS_MODE  = 'h00;
    localparam int unsigned OFS_DIR   = 'h04;
    localparam int unsigned OFS_DIN   = 'h08;
    localparam int unsigned OFS_DOUT  = 'h0C;
    localparam int unsigned OFS_SET   = 'h10;
    localparam int unsigned OFS_CLR   = 'h14;

endpackage

// File: rtl/pinctl_sync.sv
module pinctl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stg;

    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= 1'b0;
        else        stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_chain
        always_ff @(posedge clk) begin
            if (!rst_n) stg[i] <= 1'b0;
            else        stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

    // R8: each stage passes its predecessor along one edge later
    p_chain_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (q == $past(stg[STAGES-2])));

endmodule

// File: rtl/pinctl_regs.sv
module pinctl_regs
    import pinctl_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic          wbit,
    input  logic          rd_en,
    input  logic          din_sync,
    output pin_mode_e     mode,
    output logic          dout,
    output logic [DW-1:0] rd_data
);
    localparam logic [AW-1:0] A_MODE = AW'(OFS_MODE);
    localparam logic [AW-1:0] A_DIR  = AW'(OFS_DIR);
    localparam logic [AW-1:0] A_DIN  = AW'(OFS_DIN);
    localparam logic [AW-1:0] A_DOUT = AW'(OFS_DOUT);
    localparam logic [AW-1:0] A_SET  = AW'(OFS_SET);
    localparam logic [AW-1:0] A_CLR  = AW'(OFS_CLR);

    pin_mode_e state, state_nxt;
    logic      dir_q;
    logic      dout_q;
    logic      rbit;

    logic wr_mode, wr_dir, wr_dout, wr_set, wr_clr;
    assign wr_mode = wr_en && (addr == A_MODE);
    assign wr_dir  = wr_en && (addr == A_DIR);
    assign wr_dout = wr_en && (addr == A_DOUT);
    assign wr_set  = wr_en && (addr == A_SET);
    assign wr_clr  = wr_en && (addr == A_CLR);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PM_FUNC;
        else        state <= state_nxt;
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            PM_FUNC: begin
                if (wr_mode && !wbit) state_nxt = dir_q ? PM_GIO_OUT : PM_GIO_IN;
            end
            PM_GIO_IN: begin
                if (wr_mode && wbit)     state_nxt = PM_FUNC;
                else if (wr_dir && wbit) state_nxt = PM_GIO_OUT;
            end
            PM_GIO_OUT: begin
                if (wr_mode && wbit)      state_nxt = PM_FUNC;
                else if (wr_dir && !wbit) state_nxt = PM_GIO_IN;
            end
            default: state_nxt = PM_FUNC;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= 1'b0;
            dout_q <= 1'b0;
        end else begin
            if (wr_dir) dir_q <= wbit;
            if (wr_dout)            dout_q <= wbit;
            else if (wr_set && wbit) dout_q <= 1'b1;
            else if (wr_clr && wbit) dout_q <= 1'b0;
        end
    end

    // read mux
    always_comb begin
        rbit = 1'b0;
        unique case (addr)
            A_MODE:       rbit = (state == PM_FUNC);
            A_DIR:        rbit = dir_q;
            A_DIN:        rbit = din_sync;
            A_DOUT:       rbit = dout_q;
            A_SET, A_CLR: rbit = (state == PM_GIO_OUT) && dout_q;
            default:      rbit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= {{(DW-1){1'b0}}, rbit};
    end

    assign mode = state;
    assign dout = dout_q;

    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_set && wbit) |=> dout_q);
    p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && wbit) |=> !dout_q);
    p_zero_alias_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_set || wr_clr) && !wbit) |=> $stable(dout_q));
    p_alias_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr == A_SET || addr == A_CLR) && state != PM_GIO_OUT) |=> (rd_data == '0));
    p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DW-1:1] == '0);
    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/pinctl_drive.sv
module pinctl_drive
    import pinctl_pkg::*;
(
    input  pin_mode_e mode,
    input  logic      dout,
    input  logic      func_clk,
    output logic      pin_out,
    output logic      pin_oe
);
    always_comb begin
        pin_out = 1'b0;
        pin_oe  = 1'b0;
        unique case (mode)
            PM_FUNC: begin
                pin_out = func_clk;
                pin_oe  = 1'b1;
            end
            PM_GIO_OUT: begin
                pin_out = dout;
                pin_oe  = 1'b1;
            end
            PM_GIO_IN: begin
                pin_out = 1'b0;
                pin_oe  = 1'b0;
            end
            default: begin
                pin_out = 1'b0;
                pin_oe  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/pinctl_bank.sv
module pinctl_bank
    import pinctl_pkg::*;
#(
    parameter int AW          = 8,
    parameter int DW          = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_rd,
    output logic [DW-1:0] bus_rdata,
    input  logic          func_clk,
    input  logic          pin_in,
    output logic          pin_out,
    output logic          pin_oe
);
    pin_mode_e mode;
    logic      dout;
    logic      din_sync;
    logic      wdata_unused;

    assign wdata_unused = ^bus_wdata[DW-1:1];

    pinctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (din_sync)
    );

    pinctl_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .wr_en    (bus_wr),
        .wbit     (bus_wdata[0]),
        .rd_en    (bus_rd),
        .din_sync (din_sync),
        .mode     (mode),
        .dout     (dout),
        .rd_data  (bus_rdata)
    );

    pinctl_drive u_drive (
        .mode     (mode),
        .dout     (dout),
        .func_clk (func_clk),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );

    p_func_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(OFS_MODE) && bus_wdata[0]) |=> pin_oe);
    p_gio_in_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_oe |-> !pin_out);
    p_set_pin_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(OFS_SET) && bus_wdata[0] && mode == PM_GIO_OUT) |=> pin_out);

endmodule

// File: tb/pinctl_bank_bench.sv
module pinctl_bank_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        func_clk = 1'b0;
    logic        pin_in = 1'b0;
    logic        pin_out;
    logic        pin_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // model state
    bit m_func, m_dir, m_dout, m_s1, m_s2;
    logic [31:0] m_rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    pinctl_bank u_pinctl_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .func_clk(func_clk), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'h00: return {31'b0, m_func};
            8'h04: return {31'b0, m_dir};
            8'h08: return {31'b0, m_s2};
            8'h0C: return {31'b0, m_dout};
            8'h10, 8'h14: return {31'b0, (!m_func && m_dir && m_dout)};
            default: return 32'b0;
        endcase
    endfunction

    function automatic string rd_tag(input logic [7:0] a);
        case (a)
            8'h00, 8'h04: return "R7";
            8'h08: return "R8";
            8'h0C: return "R9";
            8'h10, 8'h14: return "R5";
            default: return "R10";
        endcase
    endfunction

    function automatic bit exp_oe();
        return m_func || m_dir;
    endfunction

    function automatic bit exp_pin(input bit fc);
        return m_func ? fc : (m_dir ? m_dout : 1'b0);
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    string last_rtag = "R1";

    task automatic cyc(input bit we, input bit re, input logic [7:0] a, input logic [31:0] wd, input bit pin, input bit fc);
        string ptag;
        bus_wr = we; bus_rd = re; bus_addr = a; bus_wdata = wd; pin_in = pin; func_clk = fc;
        @(posedge clk);
        #1;
        if (re) begin
            m_rd = exp_read(a);
            last_rtag = rd_tag(a);
        end
        m_s2 = m_s1; m_s1 = pin;
        ptag = "R7";
        if (we) begin
            case (a)
                8'h00: m_func = wd[0];
                8'h04: m_dir = wd[0];
                8'h0C: m_dout = wd[0];
                8'h10: begin if (wd[0]) m_dout = 1'b1; ptag = wd[0] ? "R2" : "R4"; end
                8'h14: begin if (wd[0]) m_dout = 1'b0; ptag = wd[0] ? "R3" : "R4"; end
                default: ptag = "R10";
            endcase
        end
        @(negedge clk);
        check(ptag, "pin_oe", {31'b0, pin_oe}, {31'b0, exp_oe()});
        check(ptag, "pin_out", {31'b0, pin_out}, {31'b0, exp_pin(fc)});
        check(last_rtag, "bus_rdata", bus_rdata, m_rd);
        check("R6", "upper rdata", {1'b0, bus_rdata[31:1]}, 32'b0);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] wd);
        cyc(1'b1, 1'b0, a, wd, pin_in, func_clk);
    endtask

    task automatic rd(input logic [7:0] a);
        cyc(1'b0, 1'b1, a, 32'b0, pin_in, func_clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        m_func = 1'b1; m_dir = 1'b0; m_dout = 1'b0; m_s1 = 1'b0; m_s2 = 1'b0; m_rd = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        func_clk = 1'b1;
        #1;
        check("R1", "pin_oe", {31'b0, pin_oe}, 32'd1);
        check("R1", "pin_out", {31'b0, pin_out}, 32'd1);
        check("R1", "bus_rdata", bus_rdata, 32'b0);
        func_clk = 1'b0;
        #1;
        check("R1", "pin_out low", {31'b0, pin_out}, 32'd0);
        rd(8'h00); rd(8'h04); rd(8'h0C);
        // alias read in PM_FUNC: R5
        wr(8'h0C, 32'h1); rd(8'h10); rd(8'h14);
        // into PM_GIO_IN then PM_GIO_OUT
        wr(8'h00, 32'hFFFF_FFFE);
        rd(8'h10);
        wr(8'h04, 32'h1);
        rd(8'h10);
        // R3 clear, R4 zero writes, R2 set
        wr(8'h14, 32'h1);
        wr(8'h14, 32'hFFFF_FFFE);
        wr(8'h10, 32'hFFFF_FFFE);
        wr(8'h10, 32'h1);
        rd(8'h14);
        wr(8'h14, 32'h0);
        rd(8'h0C);
        // R8 synchronizer timing and ignored writes
        cyc(1'b0, 1'b0, 8'h00, 0, 1'b1, 1'b0);
        rd(8'h08); rd(8'h08); rd(8'h08);
        wr(8'h08, 32'h0); rd(8'h08);
        // R10 unmapped offsets
        wr(8'h18, 32'hFFFF_FFFF); rd(8'h18); rd(8'h11);
        // back to PM_FUNC while dir retained
        wr(8'h00, 32'h1);
        cyc(1'b0, 1'b0, 8'h00, 0, 1'b1, 1'b1);
        rd(8'h14);
        // constrained random
        void'($urandom(32'd1234));
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] a;
            logic [31:0] wd;
            case ($urandom % 8)
                0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h08; 3: a = 8'h0C;
                4: a = 8'h10; 5: a = 8'h14; 6: a = 8'h18; default: a = 8'h11;
            endcase
            wd = $urandom;
            if (a == 8'h00 && ($urandom % 4) != 0) wd[0] = 1'b0;
            cyc(($urandom % 2) == 1, ($urandom % 2) == 1, a, wd, ($urandom % 3) == 0, ($urandom % 2) == 1);
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule